// File: doc/BRIEF.md
# ADPCM Adaptation Speed Controller

This block produces the speed-control parameter that a 32 kbit/s ADPCM coder uses to blend its fast and slow scale factors. Once per sample, marked by a one-cycle valid strobe, it takes the 4-bit codeword, the current quantizer scale factor and the tone and transition flags. It maps the codeword magnitude to a small weight. Two leaky running averages of that weight are kept, one with a short and one with a long time constant.

When the averages disagree, the scale factor is small, or a tone is flagged, the intermediate parameter ap is pushed up toward 2.0. Otherwise it decays toward zero. A flagged transition resets ap to exactly 1.0. The output al is ap limited to 1.0. It is registered and reflects a sample in the cycle after that sample's strobe.

All quantities are unsigned fixed point and every right shift truncates. All state is cleared by a synchronous active-high reset.

Top module: `adpcm_speed_ctl`

## Requirements
- R1: A synchronous reset clears both averages and ap, and drives al to 0 in the cycle after reset is sampled.
- R2: The codeword magnitude is code[2:0] and code[3] (sign) is ignored. Magnitudes 0..7 map to weights 0,0,0,1,1,1,3,7.
- R3: The short-term average has 12 fractional bits and is updated as dms - (dms>>5) + weight·2^-5.
- R4: The long-term average has 14 fractional bits and is updated as dml - (dml>>7) + weight·2^-7.
- R5: ap is increased, becoming ap - (ap>>4) + 0.125, when |4·dms - dml| >= dml>>3. This uses the averages already updated with the current sample.
- R6: ap is increased by the same rule when the scale factor (13 bits, 9 fractional bits) is below 3.0, i.e. below 1536. At exactly 1536 this condition is false.
- R7: ap is increased by the same rule when the tone flag is 1.
- R8: When none of the increase conditions holds, ap becomes ap - (ap>>4).
- R9: A transition flag of 1 sets ap to 1.0 (1024, with 10 fractional bits), overriding every other rule.
- R10: al (11 bits, 10 fractional bits) equals min(ap, 1.0) after the update. It changes at the clock edge that samples the strobe.
- R11: Without a strobe, all state and al hold, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | One-cycle strobe: a new sample's inputs are present |
| code | input | 4 | ADPCM codeword; bit 3 is the sign |
| scale | input | 13 | Quantizer scale factor, 9 fractional bits |
| tone | input | 1 | Tone detected flag |
| trans | input | 1 | Transition detected flag |
| al | output | 11 | Limited speed-control parameter, 10 fractional bits |

## Verification
The assertions check four things on every cycle. al never exceeds 1.0. A strobe with the transition flag set yields exactly 1.0. State holds on cycles without a strobe. The short average and ap stay within their ranges.

The exact arithmetic can only be shown by the bench scenarios, which compare al against an independent model over long sample streams. This covers the weight table and the truncating averages. It also covers the selection between the increase and decay rules, including the scale boundary at 1536 and the gap test after a sudden large codeword.

// File: rtl/adpcm_speed_ctl.sv
module adpcm_speed_ctl #(
  parameter int Y_W      = 13,
  parameter int Y_FRAC   = 9,
  parameter int LOW_Y    = 3,
  parameter int DMS_FRAC = 12,
  parameter int DML_FRAC = 14,
  parameter int AP_FRAC  = 10,
  parameter int SHORT_SH = 5,
  parameter int LONG_SH  = 7,
  parameter int AP_SH    = 4,
  parameter int STEP_SH  = 3,
  parameter int GAP_SH   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_vld,
  input  logic [3:0]       code,
  input  logic [Y_W-1:0]   scale,
  input  logic             tone,
  input  logic             trans,
  output logic [AP_FRAC:0] al
);
  localparam int W_INT = 3;
  localparam int DMS_W = W_INT + DMS_FRAC;
  localparam int DML_W = W_INT + DML_FRAC;
  localparam int AP_W  = AP_FRAC + 2;
  localparam logic [AP_W-1:0] ONE   = AP_W'(1) << AP_FRAC;
  localparam logic [AP_W-1:0] STEP  = AP_W'(1) << (AP_FRAC - STEP_SH);
  localparam logic [Y_W-1:0]  Y_LIM = Y_W'(LOW_Y) << Y_FRAC;

  logic [DMS_W-1:0] dms_q, dms_nx;
  logic [DML_W-1:0] dml_q, dml_nx, dms_al, gap;
  logic [AP_W-1:0]  ap_q, ap_nx, ap_dec;
  logic [W_INT-1:0] wgt;
  logic             boost;

  always_comb begin
    case (code[2:0])
      3'd3, 3'd4, 3'd5: wgt = 3'd1;
      3'd6:             wgt = 3'd3;
      3'd7:             wgt = 3'd7;
      default:          wgt = 3'd0;
    endcase
  end

  assign dms_nx = dms_q - (dms_q >> SHORT_SH) + (DMS_W'(wgt) << (DMS_FRAC - SHORT_SH));
  assign dml_nx = dml_q - (dml_q >> LONG_SH) + (DML_W'(wgt) << (DML_FRAC - LONG_SH));
  assign dms_al = DML_W'(dms_nx) << (DML_FRAC - DMS_FRAC);
  assign gap    = (dms_al >= dml_nx) ? dms_al - dml_nx : dml_nx - dms_al;
  assign boost  = (gap >= (dml_nx >> GAP_SH)) || (scale < Y_LIM) || tone;
  assign ap_dec = ap_q - (ap_q >> AP_SH);
  assign ap_nx  = trans ? ONE : (boost ? ap_dec + STEP : ap_dec);

  always_ff @(posedge clk) begin
    if (rst) begin
      dms_q <= '0;
      dml_q <= '0;
      ap_q  <= '0;
      al    <= '0;
    end else if (smp_vld) begin
      dms_q <= dms_nx;
      dml_q <= dml_nx;
      ap_q  <= ap_nx;
      al    <= (ap_nx > ONE) ? ONE[AP_FRAC:0] : ap_nx[AP_FRAC:0];
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (al == '0 && ap_q == '0 && dms_q == '0 && dml_q == '0));

  assert_dms_range_R3: assert property (@(posedge clk) disable iff (rst)
    dms_q <= (DMS_W'(7) << DMS_FRAC));

  assert_ap_range_R5: assert property (@(posedge clk) disable iff (rst)
    ap_q <= (ONE << 1));

  assert_trans_one_R9: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && trans) |=> (al == ONE[AP_FRAC:0]));

  assert_al_limit_R10: assert property (@(posedge clk) disable iff (rst)
    al <= ONE[AP_FRAC:0]);

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !smp_vld |=> ($stable(al) && $stable(ap_q) && $stable(dms_q) && $stable(dml_q)));
endmodule

// File: tb/sim_adpcm_speed_ctl.sv
`timescale 1ns/1ps
module sim_adpcm_speed_ctl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_vld = 1'b0;
  logic [3:0]  code = '0;
  logic [12:0] scale = 13'd4000;
  logic        tone = 1'b0;
  logic        trans = 1'b0;
  logic [10:0] al;

  int checks = 0, fails = 0;
  int m_dms = 0, m_dml = 0, m_ap = 0, exp_al = 0;

  always #4 clk = ~clk;

  adpcm_speed_ctl u0 (.clk(clk), .rst(rst), .smp_vld(smp_vld), .code(code),
                      .scale(scale), .tone(tone), .trans(trans), .al(al));

  task automatic chk(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic chk_true(input string tag, input bit ok, input int act, input int ref_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected relation to %0d", tag, act, ref_v);
    end
  endtask

  task automatic model(input logic [3:0] c, input int y, input bit td, input bit tr);
    int f, gap, d;
    case (c[2:0])
      3, 4, 5: f = 1;
      6:       f = 3;
      7:       f = 7;
      default: f = 0;
    endcase
    m_dms = m_dms - (m_dms >> 5) + (f << 7);
    m_dml = m_dml - (m_dml >> 7) + (f << 7);
    gap = 4 * m_dms - m_dml;
    if (gap < 0) gap = -gap;
    d = m_ap - (m_ap >> 4);
    if (tr) m_ap = 1024;
    else if (gap >= (m_dml >> 3) || y < 1536 || td) m_ap = d + 128;
    else m_ap = d;
    exp_al = (m_ap > 1024) ? 1024 : m_ap;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    smp_vld = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    m_dms = 0; m_dml = 0; m_ap = 0; exp_al = 0;
  endtask

  task automatic sample(input logic [3:0] c, input int y, input bit td, input bit tr,
                        input string tag);
    @(negedge clk);
    code = c; scale = 13'(y); tone = td; trans = tr; smp_vld = 1'b1;
    @(negedge clk);
    smp_vld = 1'b0;
    model(c, y, td, tr);
    chk(tag, int'(al), exp_al);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 al after reset", int'(al), 0);
  endtask

  task automatic t_sign();
    do_reset();
    sample(4'h8, 4000, 0, 0, "R2 sign ignored mag0 gives first boost");
    chk("R2 first sample al", int'(al), 128);
    sample(4'hE, 4000, 0, 0, "R2 mag6 weight");
    sample(4'hF, 4000, 0, 0, "R2 mag7 weight");
    sample(4'h7, 4000, 0, 0, "R2 positive mag7 weight");
    for (int i = 0; i < 8; i++) sample(4'(i + 8), 4000, 0, 0, "R2 negative codes");
    for (int i = 0; i < 8; i++) sample(4'(i), 4000, 0, 0, "R2 positive codes");
  endtask

  task automatic t_converge();
    do_reset();
    for (int i = 0; i < 1500; i++) sample(4'h3, 4000, 0, 0, "R3 R4 R8 steady weight one");
    chk_true("R8 ap decayed to small value", al < 11'd16, int'(al), 16);
  endtask

  task automatic t_tone();
    for (int i = 0; i < 60; i++) sample(4'h4, 4000, 1, 0, "R7 tone boost");
    chk("R10 al clamped at one", int'(al), 1024);
  endtask

  task automatic t_decay();
    int prev;
    for (int i = 0; i < 30; i++) sample(4'hC, 4000, 0, 0, "R8 decay after tone");
    prev = int'(al);
    chk_true("R8 al dropped below one", prev < 1024, prev, 1024);
    sample(4'h5, 4000, 0, 0, "R8 decay step");
    chk_true("R8 al decreases", int'(al) < prev, int'(al), prev);
  endtask

  task automatic t_lowscale();
    int prev;
    prev = int'(al);
    sample(4'h3, 1536, 0, 0, "R6 scale at boundary 1536");
    chk_true("R6 no boost at 1536", int'(al) < prev, int'(al), prev);
    prev = int'(al);
    sample(4'h3, 1535, 0, 0, "R6 scale below boundary");
    chk_true("R6 boost at 1535", int'(al) > prev, int'(al), prev);
  endtask

  task automatic t_gap();
    int prev;
    for (int i = 0; i < 40; i++) sample(4'h3, 4000, 0, 0, "R8 settle");
    prev = int'(al);
    sample(4'h7, 4000, 0, 0, "R5 large codeword gap");
    chk_true("R5 gap boost raises al", int'(al) > prev, int'(al), prev);
  endtask

  task automatic t_idle();
    int held;
    sample(4'h6, 1000, 0, 0, "R11 setup");
    held = int'(al);
    @(negedge clk);
    code = 4'h7; scale = 13'd10; tone = 1'b1; trans = 1'b1;
    repeat (10) @(negedge clk);
    chk("R11 al holds without strobe", int'(al), held);
    sample(4'h3, 4000, 0, 0, "R11 state intact after idle");
  endtask

  task automatic t_trans();
    sample(4'h7, 100, 1, 1, "R9 transition overrides boost");
    chk("R9 al equals one", int'(al), 1024);
    for (int i = 0; i < 5; i++) sample(4'h3, 4000, 0, 0, "R9 after transition");
    sample(4'h0, 4000, 0, 1, "R9 transition from low ap");
    chk("R9 al equals one again", int'(al), 1024);
  endtask

  task automatic t_midreset();
    for (int i = 0; i < 20; i++) sample(4'(i), 1000 + 37 * i, i % 3 == 0, 0, "R10 mixed stream");
    do_reset();
    chk("R1 al after mid-run reset", int'(al), 0);
    sample(4'h1, 4000, 0, 0, "R1 state cleared");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_sign();
    t_converge();
    t_tone();
    t_decay();
    t_lowscale();
    t_gap();
    t_idle();
    t_trans();
    t_midreset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule